// File: doc/BRIEF.md
# Segmented Pointer Adder

This block moves a pointer made of two bytes: a segment (upper byte) and an offset (lower byte). A signed step is added to the offset. When the carry gate is open, any carry out of the offset or borrow below zero is passed into the segment. The segment and offset then act as one 16-bit linear byte address that can cross segment boundaries.

A processor core uses one instance to advance its instruction pointer inside the code segment, with a step of +2 per instruction. It uses a second instance to move its stack pointer inside the stack segment, with +2 to push and -2 to pop. When the gate is closed, the segment passes through untouched and the offset wraps within its own 256 bytes.

The result is purely combinational, so the caller can register it in the same cycle. The clock input is kept for interface uniformity and does not delay the result.

Top module: `seg_ptr_add`

## Requirements
- R1: `ofs_o` always equals the low 8 bits of `ofs_i` plus `step_i`.
- R2: With `carry_en_i` low, `seg_o` equals `seg_i` for every offset and step, including steps that overflow or underflow the offset.
- R3: With `carry_en_i` high and `step_i[7]` = 0 (non-negative step), `seg_o` is `seg_i` + 1 when the unsigned sum `ofs_i` + `step_i` exceeds 0xFF. Otherwise it is `seg_i`.
- R4: With `carry_en_i` high and `step_i[7]` = 1, the step is negative in two's complement. `seg_o` is `seg_i` - 1 when `ofs_i` is less than the step's magnitude (the offset wraps below 0x00). Otherwise it is `seg_i`.
- R5: With `carry_en_i` high, {`seg_o`,`ofs_o`} equals {`seg_i`,`ofs_i`} plus the sign-extended step, modulo 2^16. A step of 0x02 advances by two bytes and a step of 0xFE moves back by two bytes.
- R6: A step of 0x00 returns `ofs_i` and `seg_i` unchanged, whatever the gate.
- R7: Outputs follow input changes in the same cycle, with no clock edge in between.
- R8: The segment wraps modulo 256: 0xFF plus a carry gives 0x00, and 0x00 minus a borrow gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, reserved; does not affect the result |
| carry_en_i | input | 1 | High: offset carry/borrow adjusts the segment |
| ofs_i | input | 8 | Current offset |
| seg_i | input | 8 | Current segment |
| step_i | input | 8 | Signed two's-complement step added to the offset |
| ofs_o | output | 8 | New offset |
| seg_o | output | 8 | New segment |

## Verification
The assertions are immediate checks that are evaluated only when every input is a known 0 or 1. This matters because the block has no reset: before the first stimulus the inputs are X, and the check stays silent until they are driven. The bench drives every input on every transaction, so from then on each check is live. Stimulus mixes directed boundary cases with random vectors. The directed cases are offsets 0x00 and 0xFF, segments 0x00 and 0xFF, and steps 0x7F, 0x80, 0x02, 0xFE and 0x00. The random vectors are applied with the gate both open and closed.

// File: rtl/seg_ptr_add.sv
module seg_ptr_add #(
  parameter int OFS_W = 8,
  parameter int SEG_W = 8
) (
  input  logic             clk_i,
  input  logic             carry_en_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFS_W-1:0] step_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [SEG_W-1:0] seg_o
);
  localparam int SUM_W = OFS_W + 1;

  logic             unused_clk;
  logic [SUM_W-1:0] sum;
  logic             neg_step;
  logic             carry_up;
  logic             borrow_dn;

  assign unused_clk = clk_i;

  assign sum       = {1'b0, ofs_i} + {1'b0, step_i};
  assign neg_step  = step_i[OFS_W-1];
  assign carry_up  = carry_en_i & ~neg_step &  sum[OFS_W];
  assign borrow_dn = carry_en_i &  neg_step & ~sum[OFS_W];

  assign ofs_o = sum[OFS_W-1:0];

  always_comb begin
    seg_o = seg_i;
    if (carry_up)
      seg_o = seg_i + SEG_W'(1);
    else if (borrow_dn)
      seg_o = seg_i - SEG_W'(1);
  end
endmodule

// File: rtl/seg_ptr_add_chk.sv
module seg_ptr_add_chk #(
  parameter int OFS_W = 8,
  parameter int SEG_W = 8
) (
  input logic             clk_i,
  input logic             carry_en_i,
  input logic [OFS_W-1:0] ofs_i,
  input logic [SEG_W-1:0] seg_i,
  input logic [OFS_W-1:0] step_i,
  input logic [OFS_W-1:0] ofs_o,
  input logic [SEG_W-1:0] seg_o
);
  localparam int LIN_W = OFS_W + SEG_W;

  logic             unused_clk;
  logic [LIN_W-1:0] lin_in;
  logic [LIN_W-1:0] lin_out;
  logic [LIN_W-1:0] step_ext;
  logic             known;

  assign unused_clk = clk_i;
  assign lin_in     = {seg_i, ofs_i};
  assign lin_out    = {seg_o, ofs_o};
  assign step_ext   = {{SEG_W{step_i[OFS_W-1]}}, step_i};
  assign known      = !$isunknown({carry_en_i, ofs_i, seg_i, step_i});

  always_comb begin
    if (known) begin
      a_r2_gate_closed: assert (carry_en_i || seg_o == seg_i);
      a_r3_up_at_most_one: assert (!carry_en_i || step_i[OFS_W-1] ||
                                   seg_o == seg_i || seg_o == seg_i + SEG_W'(1));
      a_r4_down_at_most_one: assert (!carry_en_i || !step_i[OFS_W-1] ||
                                     seg_o == seg_i || seg_o == seg_i - SEG_W'(1));
      a_r5_linear_sum: assert (!carry_en_i || lin_out == lin_in + step_ext);
      a_r6_zero_step: assert (step_i != '0 || (ofs_o == ofs_i && seg_o == seg_i));
    end
  end
endmodule

bind seg_ptr_add seg_ptr_add_chk #(.OFS_W(OFS_W), .SEG_W(SEG_W)) chk_i (
  .clk_i(clk_i), .carry_en_i(carry_en_i), .ofs_i(ofs_i), .seg_i(seg_i),
  .step_i(step_i), .ofs_o(ofs_o), .seg_o(seg_o)
);

// File: tb/seg_ptr_add_tb_top.sv
module seg_ptr_add_tb_top;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       carry_en;
  logic [7:0] ofs, seg, step;
  logic [7:0] ofs_q, seg_q;

  typedef struct {
    logic [7:0] ofs;
    logic [7:0] seg;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_ptr_add dut_i (
    .clk_i(clk), .carry_en_i(carry_en), .ofs_i(ofs), .seg_i(seg),
    .step_i(step), .ofs_o(ofs_q), .seg_o(seg_q)
  );

  function automatic exp_t model(bit ce, logic [7:0] o, logic [7:0] s,
                                 logic [7:0] st, string tag);
    exp_t e;
    logic [15:0] lin;
    lin   = {s, o} + {{8{st[7]}}, st};
    e.ofs = lin[7:0];
    e.seg = ce ? lin[15:8] : s;
    e.tag = tag;
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_chk++;
    if (ofs_q !== e.ofs || seg_q !== e.seg) begin
      n_fail++;
      $display("FAIL %s: got seg=%02h ofs=%02h expected seg=%02h ofs=%02h",
               e.tag, seg_q, ofs_q, e.seg, e.ofs);
    end
  endtask

  task automatic drive(bit ce, logic [7:0] o, logic [7:0] s, logic [7:0] st,
                       string tag);
    @(posedge clk);
    #1;
    carry_en = ce; ofs = o; seg = s; step = st;
    sb_q.push_back(model(ce, o, s, st, tag));
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) compare(sb_q.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    drive(1, 8'h10, 8'h01, 8'h02, "R1 plain advance");
    drive(0, 8'hFF, 8'h33, 8'h02, "R2 gate closed overflow");
    drive(0, 8'h00, 8'h33, 8'hFE, "R2 gate closed underflow");
    drive(1, 8'hFE, 8'h01, 8'h02, "R3 carry into segment");
    drive(1, 8'h80, 8'h05, 8'h7F, "R3 max positive step no carry");
    drive(1, 8'h81, 8'h05, 8'h7F, "R3 max positive step carry");
    drive(1, 8'h00, 8'h05, 8'hFE, "R4 borrow from segment");
    drive(1, 8'h7F, 8'h05, 8'h80, "R4 max negative step borrow");
    drive(1, 8'h80, 8'h05, 8'h80, "R4 max negative step no borrow");
    drive(1, 8'h40, 8'h22, 8'hFE, "R5 step back two");
    drive(1, 8'h5A, 8'hC3, 8'h00, "R6 zero step gate open");
    drive(0, 8'hFF, 8'h00, 8'h00, "R6 zero step gate closed");
    drive(1, 8'hFF, 8'hFF, 8'h01, "R8 segment wraps up");
    drive(1, 8'h00, 8'h00, 8'hFF, "R8 segment wraps down");
    for (int i = 0; i < 400; i++)
      drive(bit'($urandom_range(0, 1)), 8'($urandom), 8'($urandom),
            8'($urandom), "R5 random vector");
    @(posedge clk);
    @(negedge clk);
    #1;
    // R7: change inputs between edges and sample before any edge
    carry_en = 1'b1; ofs = 8'hFF; seg = 8'h0A; step = 8'h02;
    #1;
    compare(model(1, 8'hFF, 8'h0A, 8'h02, "R7 same-cycle response up"));
    carry_en = 1'b1; ofs = 8'h01; seg = 8'h0A; step = 8'hFE;
    #1;
    compare(model(1, 8'h01, 8'h0A, 8'hFE, "R7 same-cycle response down"));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule